// File: doc/BRIEF.md
# Timer Output Modulator Stage

This block drives one timer output pin from several event and data sources. The sources are compare-match pulses from a timer, the output of a duty-cycle generator, and a serial data bit with its bit-boundary and mid-bit strobes. A mode field picks how these sources become a line level. The choices are a plain toggle on compare match, two pulse-width modes that set the line on a period overflow and clear it on an 8-bit or 12-bit compare, two burst modes that gate the duty-cycle carrier, and two line codes (biphase and Manchester) for the serial data.

The modulator only runs between a start event and a stop event. It starts when the shift-register stop flag falls from 1 to 0. It stops when that flag rises, or when the timer's stage-1 compare match fires. While stopped or masked, the pin holds a programmable idle level. A polarity bit inverts the final level. The pin is driven from a register.

Top module: `tmr_out_modulator`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `tmr_out` is 0 and the modulator is stopped. The stop-flag history is reset to 1, so a low `sr_stop` after reset counts as a start.
- R2: A 1-to-0 change of `sr_stop` starts the modulator. A 0-to-1 change of `sr_stop`, or a `cmp1_evt` pulse, stops it. A stop wins over a start in the same cycle. On start, the toggle, duty and line-code states are loaded with `cfg_idle`.
- R3: While the modulator is stopped, `tmr_out` equals `cfg_idle ^ cfg_invert` one cycle later.
- R4: While `cfg_mask` is 1, `tmr_out` equals `cfg_idle ^ cfg_invert` one cycle later, whatever the mode.
- R5: `cfg_invert` = 1 inverts the pin level in every mode and state.
- R6: Mode 0 (toggle): while running, each `cmp8_evt` inverts the toggle flip-flop, and the pin follows it.
- R7: Mode 1 (8-bit duty): `ovf_evt` sets the line and `cmp8_evt` clears it. If both arrive in the same cycle, the clear wins.
- R8: Mode 2 (12-bit duty): `ovf_evt` sets the line and `cmp12_evt` clears it. `cmp8_evt` does not clear it in this mode.
- R9: Mode 3 (burst by toggle): the pin is `dcg_in` AND the toggle flip-flop, with one cycle of latency.
- R10: Mode 4 (burst by serial data): the pin is `dcg_in` AND `ser_data`, with one cycle of latency.
- R11: Mode 6 (Manchester): a bit-start strobe sets the line to `ser_data`, and the mid-bit strobe sets it to the inverse of that bit. A 1 is therefore sent high-then-low.
- R12: Mode 5 (biphase): the line inverts at every bit-start strobe, and inverts again at the mid-bit strobe only when the bit is 1.
- R13: Mode 7 is reserved and drives the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Output mode select |
| cfg_idle | input | 1 | Level held while stopped or masked |
| cfg_mask | input | 1 | Forces the idle level |
| cfg_invert | input | 1 | Final polarity inversion |
| sr_stop | input | 1 | Shift-register stop flag (1 = stopped) |
| cmp1_evt | input | 1 | Timer stage-1 compare match; stops modulation |
| cmp8_evt | input | 1 | 8-bit compare match pulse |
| cmp12_evt | input | 1 | 12-bit combined compare match pulse |
| ovf_evt | input | 1 | Period overflow pulse |
| dcg_in | input | 1 | Duty-cycle generator output |
| ser_data | input | 1 | Serial data bit |
| ser_bit_start | input | 1 | Bit-boundary strobe |
| ser_mid | input | 1 | Mid-bit strobe |
| tmr_out | output | 1 | Registered timer output pin |

## Verification
The hardest state to reach from the ports is a stop and a start landing in the same cycle. That needs `sr_stop` to fall exactly when `cmp1_evt` pulses, and the run state must then stay off with the waveform state left alone. The stimulus reaches it deliberately in a directed step. It then runs a long stretch of random strobes and flag changes across all modes, so the same collision also happens mid-bit and mid-duty-period. A behavioural model in the bench predicts the pin on every cycle, so any mismatch in start/stop priority or encoder state shows up at once.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_TOGGLE    = 3'd0,
    MD_DUTY8     = 3'd1,
    MD_DUTY12    = 3'd2,
    MD_BURST_TOG = 3'd3,
    MD_BURST_SER = 3'd4,
    MD_BIPHASE   = 3'd5,
    MD_MANCH     = 3'd6,
    MD_RSVD      = 3'd7
  } tmo_mode_e;

  typedef enum logic {
    ENC_BIPHASE = 1'b0,
    ENC_MANCH   = 1'b1
  } tmo_enc_e;
endpackage

// File: rtl/tmo_runctl.sv
module tmo_runctl (
  input  logic clk,
  input  logic rst,
  input  logic sr_stop,
  input  logic cmp1_evt,
  output logic run_q,
  output logic load,
  output logic adv
);
  logic prev_q;
  logic start_evt;
  logic stop_evt;

  always_comb begin
    start_evt = prev_q & ~sr_stop;
    stop_evt  = (~prev_q & sr_stop) | cmp1_evt;
    load      = start_evt & ~stop_evt;
    adv       = run_q & ~stop_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      run_q  <= 1'b0;
    end else begin
      prev_q <= sr_stop;
      if (stop_evt)       run_q <= 1'b0;
      else if (start_evt) run_q <= 1'b1;
    end
  end

  // R2
  stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    cmp1_evt |=> !run_q);

  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sr_stop) && !cmp1_evt) |=> run_q);
endmodule

// File: rtl/tmo_wave.sv
module tmo_wave
  import tmo_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic      adv,
  input  logic      idle,
  input  tmo_mode_e mode,
  input  logic      cmp8_evt,
  input  logic      cmp12_evt,
  input  logic      ovf_evt,
  output logic      tog_q,
  output logic      duty_q
);
  logic clr_evt;

  always_comb clr_evt = (mode == MD_DUTY12) ? cmp12_evt : cmp8_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q  <= 1'b0;
      duty_q <= 1'b0;
    end else if (load) begin
      tog_q  <= idle;
      duty_q <= idle;
    end else if (adv) begin
      if (cmp8_evt) tog_q <= ~tog_q;
      if (clr_evt)      duty_q <= 1'b0;
      else if (ovf_evt) duty_q <= 1'b1;
    end
  end

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && cmp8_evt) |=> (tog_q != $past(tog_q)));

  // R7
  duty_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && mode == MD_DUTY8 && cmp8_evt) |=> !duty_q);
endmodule

// File: rtl/tmo_line_enc.sv
module tmo_line_enc
  import tmo_pkg::*;
#(
  parameter tmo_enc_e KIND = ENC_MANCH
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic adv,
  input  logic idle,
  input  logic bit_start,
  input  logic mid,
  input  logic ser_data,
  output logic line_q
);
  logic bit_q;

  always_ff @(posedge clk) begin
    if (rst)                    bit_q <= 1'b0;
    else if (load)              bit_q <= 1'b0;
    else if (adv && bit_start)  bit_q <= ser_data;
  end

  generate
    if (KIND == ENC_MANCH) begin : g_manch
      always_ff @(posedge clk) begin
        if (rst)       line_q <= 1'b0;
        else if (load) line_q <= idle;
        else if (adv) begin
          if (bit_start) line_q <= ser_data;
          else if (mid)  line_q <= ~bit_q;
        end
      end

      // R11
      manch_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && mid && !bit_start) |=> (line_q == !$past(bit_q)));
    end else begin : g_biphase
      always_ff @(posedge clk) begin
        if (rst)       line_q <= 1'b0;
        else if (load) line_q <= idle;
        else if (adv) begin
          if (bit_start)        line_q <= ~line_q;
          else if (mid && bit_q) line_q <= ~line_q;
        end
      end

      // R12
      biphase_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && bit_start) |=> (line_q != $past(line_q)));
    end
  endgenerate
endmodule

// File: rtl/tmr_out_modulator.sv
module tmr_out_modulator
  import tmo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_idle,
  input  logic              cfg_mask,
  input  logic              cfg_invert,
  input  logic              sr_stop,
  input  logic              cmp1_evt,
  input  logic              cmp8_evt,
  input  logic              cmp12_evt,
  input  logic              ovf_evt,
  input  logic              dcg_in,
  input  logic              ser_data,
  input  logic              ser_bit_start,
  input  logic              ser_mid,
  output logic              tmr_out
);
  tmo_mode_e mode;
  logic run_q, load, adv;
  logic tog_q, duty_q, man_q, bph_q;
  logic mod_lvl;

  always_comb mode = tmo_mode_e'(cfg_mode);

  tmo_runctl i_run (
    .clk(clk), .rst(rst), .sr_stop(sr_stop), .cmp1_evt(cmp1_evt),
    .run_q(run_q), .load(load), .adv(adv)
  );

  tmo_wave i_wave (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .idle(cfg_idle),
    .mode(mode), .cmp8_evt(cmp8_evt), .cmp12_evt(cmp12_evt),
    .ovf_evt(ovf_evt), .tog_q(tog_q), .duty_q(duty_q)
  );

  tmo_line_enc #(.KIND(ENC_MANCH)) i_manch (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .idle(cfg_idle),
    .bit_start(ser_bit_start), .mid(ser_mid), .ser_data(ser_data),
    .line_q(man_q)
  );

  tmo_line_enc #(.KIND(ENC_BIPHASE)) i_biphase (
    .clk(clk), .rst(rst), .load(load), .adv(adv), .idle(cfg_idle),
    .bit_start(ser_bit_start), .mid(ser_mid), .ser_data(ser_data),
    .line_q(bph_q)
  );

  always_comb begin
    case (mode)
      MD_TOGGLE:    mod_lvl = tog_q;
      MD_DUTY8:     mod_lvl = duty_q;
      MD_DUTY12:    mod_lvl = duty_q;
      MD_BURST_TOG: mod_lvl = dcg_in & tog_q;
      MD_BURST_SER: mod_lvl = dcg_in & ser_data;
      MD_BIPHASE:   mod_lvl = bph_q;
      MD_MANCH:     mod_lvl = man_q;
      default:      mod_lvl = cfg_idle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) tmr_out <= 1'b0;
    else     tmr_out <= ((cfg_mask | ~run_q) ? cfg_idle : mod_lvl) ^ cfg_invert;
  end

  // R4
  mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_mask |=> (tmr_out == $past(cfg_idle ^ cfg_invert)));

  // R3
  stopped_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (tmr_out == $past(cfg_idle ^ cfg_invert)));

  // R13
  rsvd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 3'd7) |=> (tmr_out == $past(cfg_idle ^ cfg_invert)));

  // R9
  burst_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !cfg_mask && cfg_mode == 3'd3 && !dcg_in) |=> (tmr_out == $past(cfg_invert)));
endmodule

// File: tb/test_tmr_out_modulator.sv
module test_tmr_out_modulator;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_mode = 3'd0;
  logic cfg_idle = 1'b0, cfg_mask = 1'b0, cfg_invert = 1'b0;
  logic sr_stop = 1'b1, cmp1_evt = 1'b0, cmp8_evt = 1'b0, cmp12_evt = 1'b0;
  logic ovf_evt = 1'b0, dcg_in = 1'b0, ser_data = 1'b0;
  logic ser_bit_start = 1'b0, ser_mid = 1'b0;
  logic tmr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string req = "R1";

  tmr_out_modulator i_tmr_out_modulator (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_idle(cfg_idle),
    .cfg_mask(cfg_mask), .cfg_invert(cfg_invert), .sr_stop(sr_stop),
    .cmp1_evt(cmp1_evt), .cmp8_evt(cmp8_evt), .cmp12_evt(cmp12_evt),
    .ovf_evt(ovf_evt), .dcg_in(dcg_in), .ser_data(ser_data),
    .ser_bit_start(ser_bit_start), .ser_mid(ser_mid), .tmr_out(tmr_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit m_out, m_run, m_prev, m_tog, m_duty, m_man, m_bph, m_bit;
  always @(posedge clk) begin
    bit lvl, st, sp;
    if (rst) begin
      m_out = 0; m_run = 0; m_prev = 1; m_tog = 0;
      m_duty = 0; m_man = 0; m_bph = 0; m_bit = 0;
    end else begin
      case (cfg_mode)
        3'd0: lvl = m_tog;
        3'd1, 3'd2: lvl = m_duty;
        3'd3: lvl = dcg_in && m_tog;
        3'd4: lvl = dcg_in && ser_data;
        3'd5: lvl = m_bph;
        3'd6: lvl = m_man;
        default: lvl = cfg_idle;
      endcase
      m_out = ((cfg_mask || !m_run) ? cfg_idle : lvl) ^ cfg_invert;
      st = m_prev && !sr_stop;
      sp = (!m_prev && sr_stop) || cmp1_evt;
      m_prev = sr_stop;
      if (sp) m_run = 0;
      else if (st) begin
        m_run = 1; m_tog = cfg_idle; m_duty = cfg_idle;
        m_man = cfg_idle; m_bph = cfg_idle; m_bit = 0;
      end else if (m_run) begin
        if (cmp8_evt) m_tog = !m_tog;
        if ((cfg_mode == 3'd2) ? cmp12_evt : cmp8_evt) m_duty = 0;
        else if (ovf_evt) m_duty = 1;
        if (ser_bit_start) begin
          m_man = ser_data; m_bph = !m_bph; m_bit = ser_data;
        end else if (ser_mid) begin
          m_man = !m_bit;
          if (m_bit) m_bph = !m_bph;
        end
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (tmr_out !== m_out) begin
        errors++;
        $display("FAIL %s: tmr_out=%0b expected %0b at %0t", req, tmr_out, m_out, $time);
      end
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic pulse8(); cmp8_evt = 1; tick(1); cmp8_evt = 0; tick(3); endtask

  task automatic send_bits(int n);
    for (int i = 0; i < n; i++) begin
      ser_data = $urandom_range(0, 1);
      ser_bit_start = 1; tick(1); ser_bit_start = 0; tick(3);
      ser_mid = 1; tick(1); ser_mid = 0; tick(3);
    end
  endtask

  task automatic restart();
    sr_stop = 1; tick(2); sr_stop = 0; tick(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    checks++;
    if (tmr_out !== 1'b0) begin
      errors++; $display("FAIL R1: tmr_out=%0b expected 0", tmr_out);
    end
    rst = 0; tick(1);
    req = "R3"; cfg_idle = 1; tick(4); cfg_idle = 0; tick(2);

    req = "R6"; cfg_mode = 3'd0; sr_stop = 0; tick(2);
    repeat (5) pulse8();

    req = "R7"; cfg_mode = 3'd1;
    ovf_evt = 1; tick(1); ovf_evt = 0; tick(3); pulse8();
    ovf_evt = 1; cmp8_evt = 1; tick(1); ovf_evt = 0; cmp8_evt = 0; tick(3);

    req = "R8"; cfg_mode = 3'd2;
    ovf_evt = 1; tick(1); ovf_evt = 0; tick(2); pulse8();
    cmp12_evt = 1; tick(1); cmp12_evt = 0; tick(3);

    req = "R9"; cfg_mode = 3'd3;
    for (int i = 0; i < 24; i++) begin
      dcg_in = i[0]; if (i % 6 == 0) cmp8_evt = 1; tick(1); cmp8_evt = 0;
    end

    req = "R10"; cfg_mode = 3'd4;
    for (int i = 0; i < 24; i++) begin
      dcg_in = i[0]; ser_data = i[2]; tick(1);
    end

    req = "R11"; cfg_mode = 3'd6; restart(); send_bits(8);
    req = "R12"; cfg_mode = 3'd5; restart(); send_bits(8);

    req = "R4"; cfg_mask = 1; cfg_idle = 1; send_bits(2); cfg_mask = 0; cfg_idle = 0;
    req = "R5"; cfg_invert = 1; send_bits(3); cfg_mode = 3'd0; pulse8(); pulse8();
    req = "R13"; cfg_mode = 3'd7; cfg_idle = 1; tick(4); cfg_idle = 0; tick(2);
    cfg_invert = 0;

    req = "R2"; cfg_mode = 3'd0;
    cmp1_evt = 1; tick(1); cmp1_evt = 0; pulse8(); pulse8();
    sr_stop = 1; tick(2); sr_stop = 0; cmp1_evt = 1; tick(1); cmp1_evt = 0;
    pulse8(); pulse8();
    restart(); pulse8(); sr_stop = 1; tick(1); pulse8(); sr_stop = 0; tick(1); pulse8();

    req = "R2 random";
    for (int i = 0; i < 4000; i++) begin
      if (i % 400 == 0) begin
        cfg_mode = 3'($urandom_range(0, 7));
        cfg_idle = 1'($urandom_range(0, 1));
        cfg_invert = 1'($urandom_range(0, 1));
      end
      cfg_mask = ($urandom_range(0, 63) == 0);
      if ($urandom_range(0, 49) == 0) sr_stop = ~sr_stop;
      cmp1_evt = ($urandom_range(0, 99) == 0);
      cmp8_evt = ($urandom_range(0, 5) == 0);
      cmp12_evt = ($urandom_range(0, 5) == 0);
      ovf_evt = ($urandom_range(0, 4) == 0);
      dcg_in = 1'($urandom_range(0, 1));
      ser_data = 1'($urandom_range(0, 1));
      ser_bit_start = (i % 8 == 0);
      ser_mid = (i % 8 == 4);
      tick(1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule